// File: doc/BRIEF.md
# Three-Pointer Effective Address Generator

This block turns three pointer register values into effective addresses for a register-indirect, three-operand instruction form. A prefix names two source pointers (A and B). The instruction that follows names a destination pointer (C) and carries a 10-bit immediate mode word. For each pointer, a 2-bit code in the mode word picks how the pointer is used. One 4-bit offset field is shared by all three pointers.

For each pointer the block gives the effective address that operand access must use. It also gives the value to write back into that pointer register and a write enable. Several pointer roles can name the same register. In that case only the most important write-back goes ahead, so the register file never sees two writes to one entry. The results are registered and appear one cycle after the request. Operand reads and execution happen downstream.

A static parameter picks how the offset field is read: as an unsigned count, or as a sign-plus-magnitude step drawn from a short power-of-two table.

Top module: `tri_ptr_agen`

## Requirements
- R1: The mode word places the A code in bits 9:8, the B code in bits 7:6, the C code in bits 5:4 and the shared offset field in bits 3:0.
- R2: Code 00 (direct) gives the effective address equal to the pointer, and the pointer's write enable stays low.
- R3: Code 01 (pre-offset, keep) gives the effective address equal to pointer plus offset, and the write enable stays low.
- R4: Code 10 (pre-offset, update) gives the effective address equal to pointer plus offset. It also gives write-back data equal to pointer plus offset, with the write enable raised.
- R5: Code 11 (post-offset, update) gives the effective address equal to the unmodified pointer. It also gives write-back data equal to pointer plus offset, with the write enable raised.
- R6: With STEP_TBL = 0, the offset is the unsigned value of bits 3:0 (0 to 15).
- R7: With STEP_TBL = 1, bit 3 is a sign and bits 2:0 pick a magnitude: 000 gives 0, 001 gives 1, 010 gives 2, 011 gives 4 and 100 gives 16. Codes 101, 110 and 111 give 0. When the sign bit is set, the step is the negated magnitude.
- R8: All pointer arithmetic is 9 bits wide and wraps modulo 512.
- R9: When two update-mode pointers name the same register index, only one write enable is raised. C wins over B and A, and B wins over A. The write-back data is pointer plus offset for codes 10 and 11 even when the enable is suppressed, and the unchanged pointer otherwise.
- R10: Outputs update one clock after a cycle with req_valid high, and out_valid is high exactly then. All write enables are low whenever out_valid is low.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inputs hold a request this cycle |
| mode_word | input | 10 | Immediate mode: three codes and the offset field |
| ptr_a | input | 9 | Value of source pointer A |
| ptr_b | input | 9 | Value of source pointer B |
| ptr_c | input | 9 | Value of destination pointer C |
| idx_a | input | 9 | Register index holding pointer A |
| idx_b | input | 9 | Register index holding pointer B |
| idx_c | input | 9 | Register index holding pointer C |
| out_valid | output | 1 | Outputs hold a result |
| ea_a | output | 9 | Effective address for A |
| ea_b | output | 9 | Effective address for B |
| ea_c | output | 9 | Effective address for C |
| wb_a | output | 9 | Write-back data for pointer A |
| wb_b | output | 9 | Write-back data for pointer B |
| wb_c | output | 9 | Write-back data for pointer C |
| wb_en_a | output | 1 | Write enable for pointer A |
| wb_en_b | output | 1 | Write enable for pointer B |
| wb_en_c | output | 1 | Write enable for pointer C |

## Verification
The bench builds two copies side by side, one with STEP_TBL = 0 and one with STEP_TBL = 1, and feeds both the same stimulus. This covers the unsigned offsets and the signed step table, including the three unused magnitude codes, in one run. Register indices are drawn from a range of four values, so index collisions between roles are frequent and every arbitration pairing is reached. Directed vectors drive pointers near 0 and 511 with large steps in both directions to reach modulo-512 wrap.

// File: rtl/tri_ptr_agen_pkg.sv
package tri_ptr_agen_pkg;
  localparam int unsigned PTR_W  = 9;
  localparam int unsigned IDX_W  = 9;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned OFS_W  = 4;
  localparam int unsigned MODE_W = 3 * CODE_W + OFS_W;
  localparam int unsigned NPTR   = 3;

  typedef enum logic [CODE_W-1:0] {
    AM_DIRECT   = 2'b00,
    AM_PRE_KEEP = 2'b01,
    AM_PRE_UPD  = 2'b10,
    AM_POST_UPD = 2'b11
  } am_code_e;

  typedef struct packed {
    logic [PTR_W-1:0] ea;
    logic [PTR_W-1:0] wb;
    logic             upd;
  } ptr_res_t;

  // magnitude of a signed-table step, bits 2:0 of the offset field
  function automatic logic [PTR_W-1:0] step_mag(input logic [2:0] sel);
    logic [PTR_W-1:0] m;
    unique case (sel)
      3'd1:    m = PTR_W'(1);
      3'd2:    m = PTR_W'(2);
      3'd3:    m = PTR_W'(4);
      3'd4:    m = PTR_W'(16);
      default: m = '0;
    endcase
    return m;
  endfunction

  // apply an addressing code to one pointer
  function automatic ptr_res_t eval_ptr(input am_code_e code,
                                        input logic [PTR_W-1:0] ptr,
                                        input logic [PTR_W-1:0] step);
    ptr_res_t r;
    logic [PTR_W-1:0] moved;
    moved = ptr + step;
    r.upd = (code == AM_PRE_UPD) || (code == AM_POST_UPD);
    r.wb  = r.upd ? moved : ptr;
    r.ea  = ((code == AM_PRE_KEEP) || (code == AM_PRE_UPD)) ? moved : ptr;
    return r;
  endfunction
endpackage

// File: rtl/tri_ptr_step_decode.sv
module tri_ptr_step_decode
  import tri_ptr_agen_pkg::*;
#(
  parameter bit STEP_TBL = 1'b0
) (
  input  logic [OFS_W-1:0] ofs_field,
  output logic [PTR_W-1:0] step
);
  generate
    if (STEP_TBL) begin : g_signed
      logic [PTR_W-1:0] mag;
      always_comb begin
        mag  = step_mag(ofs_field[2:0]);
        step = ofs_field[OFS_W-1] ? (~mag + PTR_W'(1)) : mag;
      end
    end else begin : g_raw
      assign step = PTR_W'(ofs_field);
    end
  endgenerate
endmodule

// File: rtl/tri_ptr_unit.sv
module tri_ptr_unit
  import tri_ptr_agen_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  step,
  output ptr_res_t          res
);
  always_comb res = eval_ptr(am_code_e'(code), ptr, step);
endmodule

// File: rtl/tri_ptr_wb_arb.sv
module tri_ptr_wb_arb
  import tri_ptr_agen_pkg::*;
(
  input  logic [NPTR-1:0]            upd_req,
  input  logic [NPTR-1:0][IDX_W-1:0] idx,
  output logic [NPTR-1:0]            upd_gnt
);
  // slot 2 = C (highest), 1 = B, 0 = A
  always_comb begin
    for (int i = 0; i < NPTR; i++) begin
      upd_gnt[i] = upd_req[i];
      for (int j = i + 1; j < NPTR; j++) begin
        if (upd_req[j] && (idx[j] == idx[i])) upd_gnt[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tri_ptr_agen.sv
module tri_ptr_agen
  import tri_ptr_agen_pkg::*;
#(
  parameter bit STEP_TBL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] mode_word,
  input  logic [PTR_W-1:0]  ptr_a,
  input  logic [PTR_W-1:0]  ptr_b,
  input  logic [PTR_W-1:0]  ptr_c,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [IDX_W-1:0]  idx_c,
  output logic              out_valid,
  output logic [PTR_W-1:0]  ea_a,
  output logic [PTR_W-1:0]  ea_b,
  output logic [PTR_W-1:0]  ea_c,
  output logic [PTR_W-1:0]  wb_a,
  output logic [PTR_W-1:0]  wb_b,
  output logic [PTR_W-1:0]  wb_c,
  output logic              wb_en_a,
  output logic              wb_en_b,
  output logic              wb_en_c
);
  localparam int unsigned CODE_LSB = OFS_W;

  logic [PTR_W-1:0]            step;
  logic [NPTR-1:0][PTR_W-1:0]  ptr_v;
  logic [NPTR-1:0][IDX_W-1:0]  idx_v;
  ptr_res_t [NPTR-1:0]         res_v;
  logic [NPTR-1:0]             upd_req;
  logic [NPTR-1:0]             upd_gnt;

  assign ptr_v = {ptr_c, ptr_b, ptr_a};
  assign idx_v = {idx_c, idx_b, idx_a};

  tri_ptr_step_decode #(.STEP_TBL(STEP_TBL)) u_step (
    .ofs_field (mode_word[OFS_W-1:0]),
    .step      (step)
  );

  // slot k takes code field k: A at top (k=0), C just above offset (k=2)
  generate
    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
      localparam int unsigned LSB = CODE_LSB + (NPTR - 1 - k) * CODE_W;
      tri_ptr_unit u_unit (
        .code (mode_word[LSB +: CODE_W]),
        .ptr  (ptr_v[k]),
        .step (step),
        .res  (res_v[k])
      );
      assign upd_req[k] = res_v[k].upd;
    end
  endgenerate

  tri_ptr_wb_arb u_arb (
    .upd_req (upd_req),
    .idx     (idx_v),
    .upd_gnt (upd_gnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea_a <= '0; ea_b <= '0; ea_c <= '0;
      wb_a <= '0; wb_b <= '0; wb_c <= '0;
      wb_en_a <= 1'b0; wb_en_b <= 1'b0; wb_en_c <= 1'b0;
    end else begin
      out_valid <= req_valid;
      ea_a <= res_v[0].ea;
      ea_b <= res_v[1].ea;
      ea_c <= res_v[2].ea;
      wb_a <= res_v[0].wb;
      wb_b <= res_v[1].wb;
      wb_c <= res_v[2].wb;
      wb_en_a <= req_valid & upd_gnt[0];
      wb_en_b <= req_valid & upd_gnt[1];
      wb_en_c <= req_valid & upd_gnt[2];
    end
  end
endmodule

// File: rtl/tri_ptr_agen_chk.sv
module tri_ptr_agen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [9:0] mode_word,
  input logic [8:0] ptr_a,
  input logic [8:0] ptr_b,
  input logic [8:0] ptr_c,
  input logic [8:0] idx_a,
  input logic [8:0] idx_b,
  input logic [8:0] idx_c,
  input logic       out_valid,
  input logic [8:0] ea_a,
  input logic [8:0] ea_b,
  input logic [8:0] ea_c,
  input logic       wb_en_a,
  input logic       wb_en_b,
  input logic       wb_en_c
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en_a && !wb_en_b && !wb_en_c)); // R10
  AST_DIRECT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[9:8] == 2'b00) |=> (ea_a == $past(ptr_a) && !wb_en_a)); // R2
  AST_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[7:6] == 2'b01) |=> !wb_en_b); // R3
  AST_POST_C: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[5:4] == 2'b11) |=> (ea_c == $past(ptr_c) && wb_en_c)); // R5
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[2:0] == 3'b000 && !mode_word[3]) |=> (ea_b == $past(ptr_b))); // R7
  AST_C_OVER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[5] && mode_word[7] && idx_b == idx_c) |=> (!wb_en_b && wb_en_c)); // R9
  AST_B_OVER_A: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_word[7] && mode_word[9] && idx_a == idx_b) |=> !wb_en_a); // R9
endmodule

bind tri_ptr_agen tri_ptr_agen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_word(mode_word),
  .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_c(ptr_c),
  .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
  .out_valid(out_valid), .ea_a(ea_a), .ea_b(ea_b), .ea_c(ea_c),
  .wb_en_a(wb_en_a), .wb_en_b(wb_en_b), .wb_en_c(wb_en_c)
);

// File: tb/sim_tri_ptr_agen.sv
`timescale 1ns/1ps
module sim_tri_ptr_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [9:0] mode_word = '0;
  logic [8:0] ptr_a = '0, ptr_b = '0, ptr_c = '0;
  logic [8:0] idx_a = '0, idx_b = '0, idx_c = '0;

  logic       v0, v1;
  logic [8:0] e0a, e0b, e0c, w0a, w0b, w0c, e1a, e1b, e1c, w1a, w1b, w1c;
  logic       n0a, n0b, n0c, n1a, n1b, n1c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tri_ptr_agen #(.STEP_TBL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_word(mode_word),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_c(ptr_c),
    .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .out_valid(v0), .ea_a(e0a), .ea_b(e0b), .ea_c(e0c),
    .wb_a(w0a), .wb_b(w0b), .wb_c(w0c),
    .wb_en_a(n0a), .wb_en_b(n0b), .wb_en_c(n0c));

  tri_ptr_agen #(.STEP_TBL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_word(mode_word),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_c(ptr_c),
    .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .out_valid(v1), .ea_a(e1a), .ea_b(e1b), .ea_c(e1c),
    .wb_a(w1a), .wb_b(w1b), .wb_c(w1c),
    .wb_en_a(n1a), .wb_en_b(n1b), .wb_en_c(n1c));

  // R6 / R7: offset value as an integer, then folded to 9 bits (R8)
  function automatic logic [8:0] ref_step(input logic [3:0] f, input bit tbl);
    int v;
    if (!tbl) return {5'b0, f};
    case (f[2:0])
      3'd1: v = 1;
      3'd2: v = 2;
      3'd3: v = 4;
      3'd4: v = 16;
      default: v = 0;
    endcase
    if (f[3]) v = -v;
    return v[8:0];
  endfunction

  function automatic string code_tag(input logic [1:0] c);
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // check one pointer role of one copy
  task automatic chk_ptr(input bit tbl, input string nm, input logic [1:0] code,
                         input logic [8:0] p, input logic exp_en,
                         input logic [8:0] ea, input logic [8:0] wb, input logic en);
    logic [8:0] st, mv;
    string tg;
    st = ref_step(mode_word[3:0], tbl);
    mv = p + st;                       // R8: 9-bit wrap
    tg = $sformatf("R1/%s/%s/R8", code_tag(code), tbl ? "R7" : "R6");
    chk(tg, {nm, " ea"}, ea, (code == 2'b01 || code == 2'b10) ? mv : p);
    chk({tg, "/R9"}, {nm, " wb data"}, wb, code[1] ? mv : p);
    chk({code_tag(code), "/R9/R10"}, {nm, " wb enable"}, {8'b0, en}, {8'b0, exp_en});
  endtask

  task automatic apply(input logic [9:0] m, input logic [8:0] pa, input logic [8:0] pb,
                       input logic [8:0] pc, input logic [8:0] ia, input logic [8:0] ib,
                       input logic [8:0] ic);
    logic ra, rb, rc, ga, gb, gc;
    @(negedge clk);
    mode_word = m; ptr_a = pa; ptr_b = pb; ptr_c = pc;
    idx_a = ia; idx_b = ib; idx_c = ic; req_valid = 1'b1;
    @(negedge clk);
    ra = m[9]; rb = m[7]; rc = m[5];
    gc = rc;                                            // R9
    gb = rb && !(rc && ic == ib);
    ga = ra && !(rc && ic == ia) && !(rb && ib == ia);
    chk("R10", "u0 out_valid", {8'b0, v0}, 9'd1);
    chk("R10", "u1 out_valid", {8'b0, v1}, 9'd1);
    chk_ptr(1'b0, "u0 A", m[9:8], pa, ga, e0a, w0a, n0a);
    chk_ptr(1'b0, "u0 B", m[7:6], pb, gb, e0b, w0b, n0b);
    chk_ptr(1'b0, "u0 C", m[5:4], pc, gc, e0c, w0c, n0c);
    chk_ptr(1'b1, "u1 A", m[9:8], pa, ga, e1a, w1a, n1a);
    chk_ptr(1'b1, "u1 B", m[7:6], pb, gb, e1b, w1b, n1b);
    chk_ptr(1'b1, "u1 C", m[5:4], pc, gc, e1c, w1c, n1c);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // R11: reset state, inputs active
    req_valid = 1'b1; mode_word = 10'b11_11_11_0101; ptr_a = 9'd7;
    repeat (3) @(negedge clk);
    chk("R11", "u0 out_valid in reset", {8'b0, v0}, 9'd0);
    chk("R11", "u1 out_valid in reset", {8'b0, v1}, 9'd0);
    chk("R11", "u0 ea_a in reset", e0a, 9'd0);
    chk("R11", "u1 wb_c in reset", w1c, 9'd0);
    chk("R11", "u0 enables in reset", {6'b0, n0a, n0b, n0c}, 9'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle out_valid", {8'b0, v0}, 9'd0);

    // directed corners
    apply(10'b00_01_10_0000, 9'd5, 9'd6, 9'd7, 9'd1, 9'd2, 9'd3);        // zero offset, R2/R3/R4
    apply(10'b10_11_01_1111, 9'd511, 9'd500, 9'd1, 9'd1, 9'd2, 9'd3);    // R8 wrap up; u1: -0 (mag 7)
    apply(10'b10_10_10_1100, 9'd3, 9'd0, 9'd10, 9'd4, 9'd4, 9'd4);       // R9 all same idx; u1 -16 wraps
    apply(10'b11_11_00_0100, 9'd508, 9'd20, 9'd30, 9'd9, 9'd9, 9'd9);    // R9 B over A, C direct
    apply(10'b11_00_11_1011, 9'd0, 9'd0, 9'd2, 9'd8, 9'd1, 9'd8);        // R9 C over A; u1 -4
    apply(10'b01_01_01_0101, 9'd100, 9'd200, 9'd300, 9'd0, 9'd0, 9'd0); // R3 no writes; u1 mag 5 -> 0
    apply(10'b10_10_11_0110, 9'd1, 9'd2, 9'd3, 9'd0, 9'd1, 9'd2);        // no collisions; u1 mag 6
    apply(10'b10_01_10_1001, 9'd0, 9'd1, 9'd0, 9'd0, 9'd1, 9'd2);        // u1 -1 wraps to 511

    // random stimulus, small index range for frequent collisions
    for (int i = 0; i < 600; i++) begin
      apply(10'($urandom), 9'($urandom), 9'($urandom), 9'($urandom),
            9'($urandom_range(0, 3)), 9'($urandom_range(0, 3)), 9'($urandom_range(0, 3)));
    end

    // R10: drop the request, outputs go idle with no writes
    @(negedge clk);
    req_valid = 1'b0; mode_word = 10'b11_11_11_0001;
    @(negedge clk);
    chk("R10", "u0 out_valid after idle", {8'b0, v0}, 9'd0);
    chk("R10", "u1 out_valid after idle", {8'b0, v1}, 9'd0);
    chk("R10", "u0 enables after idle", {6'b0, n0a, n0b, n0c}, 9'd0);
    chk("R10", "u1 enables after idle", {6'b0, n1a, n1b, n1c}, 9'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule